// File: doc/BRIEF.md
# Double-Buffered DAC Interface Register

This block is the digital front end of a parallel-input 8-bit voltage converter. It has two storage stages. A staging register takes the 8-bit bus. A code register feeds the converter and is the only stage that sets the converter code. The control lines are active-low and level-sensitive. A write strobe is shared by both stages. A select line enables the staging register, and a transfer line enables the code register. While a stage's enable and the write strobe are both low, that stage follows its source. When write returns high, the stage keeps the last value it followed. If all three lines are held low, the bus reaches the converter code directly.

A separate active-low zero-override input clears the code register. It has no effect on the staging register. A system calibration routine can use it to park the converter at code zero.

The block runs on a fast system clock. Every control line and every data bit passes through a two-flop synchronizer before use, and the level behaviour is rebuilt from the synchronized copies. The block also checks two timing rules against a parameter count of system clocks: the width of each write pulse, and how long the data is stable before write rises. If either is too short, it sets a sticky timing-error flag.

Top module: `dac_dbuf_front`

## Requirements
- R1: After the system reset `rstN` is released, `dacCode` is 0x00, the staging register holds 0x00 and `timingErr` is 0.
- R2: While `selN` and `wrN` are both low, the staging register follows `busData`. When `wrN` rises, it keeps the last value it followed. Bus changes made while the stage is closed are ignored.
- R3: While `xferN` and `wrN` are both low, the code register follows the staging register. At all other times it holds its value. A load of the staging register alone leaves `dacCode` unchanged.
- R4: While `selN`, `xferN` and `wrN` are all low and `zeroN` is high, `dacCode` tracks `busData`.
- R5: While `zeroN` is low, `dacCode` is 0x00, even when a transfer is requested. The staging register keeps its contents, so a later transfer restores the staged value.
- R6: A change on any control or data input appears on `dacCode` at the third rising clock edge after it. It is unchanged at the second edge.
- R7: A write pulse shorter than `MIN_WR_CLKS` synchronized low cycles sets `timingErr`. A pulse of exactly `MIN_WR_CLKS` cycles does not set it. Once set, `timingErr` stays at 1 until `rstN` is asserted.
- R8: If a stage is enabled when `wrN` rises, and `busData` has been stable for fewer than `MIN_SETUP_CLKS` cycles, `timingErr` is set.
- R9: `busData[7]` is the MSB and `busData[0]` is the LSB. Coding is straight binary, and `dacCode` equals the captured bus value bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| selN | input | 1 | Active-low enable of the staging register |
| wrN | input | 1 | Active-low write strobe shared by both stages |
| xferN | input | 1 | Active-low enable of the code register |
| zeroN | input | 1 | Active-low zero override of the converter code |
| busData | input | 8 | Parallel data bus, bit 7 is the MSB |
| dacCode | output | 8 | Code that drives the converter |
| timingErr | output | 1 | Sticky flag for a write-pulse or data-setup violation |

## Verification
The staging register has no port of its own. A wrong value in it shows on `dacCode` only after a later transfer. The bench therefore follows each staging-only load with a transfer, and it does the same after a zero override, to bring the hidden contents out. A fault in the code register or in the zero override shows on `dacCode` exactly three clock edges after the stimulus. A wrong boundary in either timing counter shows on `timingErr` a few cycles after the write strobe rises. The bench tests pulse widths just inside and just outside the limit.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  typedef struct packed {
    logic inLoad;   // staging register transparent
    logic dacLoad;  // code register transparent
    logic dacZero;  // zero override active
  } ctlStrobes_t;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[i] <= RST_VAL;
        else       stage[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[i] <= RST_VAL;
        else       stage[i] <= stage[i-1];
      end
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/dacfe_ctl.sv
module dacfe_ctl
  import dacfe_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned MIN_WR_CLKS = 9,
  parameter int unsigned MIN_SETUP_CLKS = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          selS,
  input  logic          wrS,
  input  logic          xferS,
  input  logic          zeroS,
  input  logic [DW-1:0] dataS,
  output ctlStrobes_t   strb,
  output logic          timingErr
);
  localparam int unsigned WCW = $clog2(MIN_WR_CLKS + 1);
  localparam int unsigned SCW = $clog2(MIN_SETUP_CLKS + 1);
  localparam logic [WCW-1:0] WR_LIM = WCW'(MIN_WR_CLKS);
  localparam logic [SCW-1:0] SU_LIM = SCW'(MIN_SETUP_CLKS);

  logic           wrPrev;
  logic           openPrev;
  logic [DW-1:0]  dataPrev;
  logic [WCW-1:0] wrLowCnt;
  logic [SCW-1:0] stableCnt;
  logic           wrRise;
  logic           shortPulse;
  logic           shortSetup;

  always_comb begin
    strb.inLoad  = !selS && !wrS;
    strb.dacLoad = !xferS && !wrS;
    strb.dacZero = !zeroS;
  end

  assign wrRise     = wrS && !wrPrev;
  assign shortPulse = wrLowCnt < WR_LIM;
  assign shortSetup = openPrev && (stableCnt < SU_LIM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev    <= 1'b1;
      openPrev  <= 1'b0;
      dataPrev  <= '0;
      wrLowCnt  <= '0;
      stableCnt <= '0;
      timingErr <= 1'b0;
    end else begin
      wrPrev   <= wrS;
      openPrev <= !selS || !xferS;
      dataPrev <= dataS;
      if (wrS)                   wrLowCnt <= '0;
      else if (wrLowCnt != WR_LIM) wrLowCnt <= wrLowCnt + 1'b1;
      if (dataS != dataPrev)     stableCnt <= '0;
      else if (stableCnt != SU_LIM) stableCnt <= stableCnt + 1'b1;
      if (wrRise && (shortPulse || shortSetup)) timingErr <= 1'b1;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    timingErr |=> timingErr); // R7

  AST_FULL_PULSE_NO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (!timingErr && wrRise && wrLowCnt == WR_LIM && !openPrev) |=> !timingErr); // R7
endmodule

// File: rtl/dacfe_dp.sv
module dacfe_dp
  import dacfe_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobes_t   strb,
  input  logic [DW-1:0] dataIn,
  output logic [DW-1:0] codeOut
);
  logic [DW-1:0] stageReg;
  logic [DW-1:0] stageNext;
  logic [DW-1:0] codeReg;

  assign stageNext = strb.inLoad ? dataIn : stageReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageReg <= '0;
      codeReg  <= '0;
    end else begin
      stageReg <= stageNext;
      if (strb.dacZero)      codeReg <= '0;
      else if (strb.dacLoad) codeReg <= stageNext;
    end
  end

  assign codeOut = codeReg;

  AST_ZERO_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.dacZero |=> (codeOut == '0)); // R5

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.inLoad |=> $stable(stageReg)); // R2

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.dacLoad && !strb.dacZero) |=> $stable(codeOut)); // R3

  AST_FLOW_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inLoad && strb.dacLoad && !strb.dacZero) |=> (codeOut == $past(dataIn))); // R4
endmodule

// File: rtl/dac_dbuf_front.sv
module dac_dbuf_front
  import dacfe_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_WR_CLKS = 9,
  parameter int unsigned MIN_SETUP_CLKS = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          selN,
  input  logic          wrN,
  input  logic          xferN,
  input  logic          zeroN,
  input  logic [DW-1:0] busData,
  output logic [DW-1:0] dacCode,
  output logic          timingErr
);
  localparam int unsigned NCTL = 4;

  logic [NCTL-1:0] ctlRaw;
  logic [NCTL-1:0] ctlSync;
  logic [DW-1:0]   dataSync;
  ctlStrobes_t     strb;

  assign ctlRaw = {zeroN, xferN, wrN, selN};

  dacfe_sync #(.W(NCTL), .STAGES(SYNC_STAGES), .RST_VAL({NCTL{1'b1}})) u_ctlSync (
    .clk(clk), .rstN(rstN), .din(ctlRaw), .dout(ctlSync));

  dacfe_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL({DW{1'b0}})) u_dataSync (
    .clk(clk), .rstN(rstN), .din(busData), .dout(dataSync));

  dacfe_ctl #(.DW(DW), .MIN_WR_CLKS(MIN_WR_CLKS), .MIN_SETUP_CLKS(MIN_SETUP_CLKS)) u_ctl (
    .clk(clk), .rstN(rstN),
    .selS(ctlSync[0]), .wrS(ctlSync[1]), .xferS(ctlSync[2]), .zeroS(ctlSync[3]),
    .dataS(dataSync), .strb(strb), .timingErr(timingErr));

  dacfe_dp #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(dataSync), .codeOut(dacCode));
endmodule

// File: tb/sim_dac_dbuf_front.sv
module sim_dac_dbuf_front;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b1, wrN = 1'b1, xferN = 1'b1, zeroN = 1'b1;
  logic [7:0] busData = 8'h00;
  logic [7:0] dacCode;
  logic timingErr;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dac_dbuf_front u0 (.clk(clk), .rstN(rstN), .selN(selN), .wrN(wrN), .xferN(xferN),
    .zeroN(zeroN), .busData(busData), .dacCode(dacCode), .timingErr(timingErr));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // write pulse of n clocks with chosen enables
  task automatic pulse(input logic useSel, input logic useXfer, input int n);
    @(negedge clk);
    selN = !useSel; xferN = !useXfer; wrN = 1'b0;
    waitN(n);
    wrN = 1'b1; selN = 1'b1; xferN = 1'b1;
    waitN(5);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    selN = 1'b1; wrN = 1'b1; xferN = 1'b1; zeroN = 1'b1;
    waitN(3); rstN = 1'b1; waitN(12);
  endtask

  task automatic testReset();
    doReset();
    chk("R1 code after reset", dacCode, 8'h00);
    chk("R1 flag after reset", timingErr, 0);
    pulse(1'b0, 1'b1, 12);
    chk("R1 staging reg holds zero", dacCode, 8'h00);
  endtask

  task automatic testStageOnly();
    busData = 8'hA5; waitN(2);
    pulse(1'b1, 1'b0, 12);
    chk("R3 staging load leaves code", dacCode, 8'h00);
    busData = 8'h3C; waitN(12);
    pulse(1'b0, 1'b1, 12);
    chk("R2 r3_ transfer of captured value", dacCode, 8'hA5);
  endtask

  task automatic testBitOrder();
    busData = 8'h80; waitN(2);
    pulse(1'b1, 1'b0, 12); pulse(1'b0, 1'b1, 12);
    chk("R9 msb", dacCode, 8'h80);
    busData = 8'h01; waitN(2);
    pulse(1'b1, 1'b0, 12); pulse(1'b0, 1'b1, 12);
    chk("R9 lsb", dacCode, 8'h01);
  endtask

  task automatic testFlow();
    @(negedge clk); selN = 1'b0; xferN = 1'b0; wrN = 1'b0;
    waitN(5);
    busData = 8'h5A;
    waitN(2);
    chk("R6 unchanged at 2nd edge", dacCode, 8'h01);
    waitN(1);
    chk("R6 r4_ new at 3rd edge", dacCode, 8'h5A);
    busData = 8'hC3; waitN(12);
    chk("R4 flow through", dacCode, 8'hC3);
    wrN = 1'b1; selN = 1'b1; xferN = 1'b1; waitN(3);
    busData = 8'h11; waitN(12);
    chk("R2 capture on write rise", dacCode, 8'hC3);
  endtask

  task automatic testZero();
    busData = 8'h77; waitN(2);
    pulse(1'b1, 1'b0, 12);
    @(negedge clk); zeroN = 1'b0; waitN(5);
    chk("R5 zero override", dacCode, 8'h00);
    pulse(1'b0, 1'b1, 12);
    chk("R5 zero beats transfer", dacCode, 8'h00);
    zeroN = 1'b1; waitN(5);
    chk("R5 code stays cleared", dacCode, 8'h00);
    pulse(1'b0, 1'b1, 12);
    chk("R5 staging retained", dacCode, 8'h77);
    chk("R7 no flag on legal pulses", timingErr, 0);
  endtask

  task automatic testShortWrite();
    pulse(1'b0, 1'b0, 3);
    chk("R7 short write flagged", timingErr, 1);
    chk("R7 code unchanged", dacCode, 8'h77);
    waitN(20);
    chk("R7 flag sticky", timingErr, 1);
    doReset();
    chk("R7 r1_ reset clears flag", timingErr, 0);
    chk("R1 reset clears code", dacCode, 8'h00);
  endtask

  task automatic testBoundaries();
    busData = 8'h42; waitN(12);
    pulse(1'b1, 1'b0, 9);
    chk("R7 exact minimum pulse ok", timingErr, 0);
    pulse(1'b0, 1'b1, 12);
    chk("R2 boundary pulse captured", dacCode, 8'h42);
    pulse(1'b1, 1'b0, 8);
    chk("R7 one short flagged", timingErr, 1);
    doReset();
    busData = 8'h22; waitN(12);
    @(negedge clk); selN = 1'b0; wrN = 1'b0;
    waitN(12);
    busData = 8'h99; waitN(2);
    wrN = 1'b1; selN = 1'b1; waitN(5);
    chk("R8 short data setup flagged", timingErr, 1);
  endtask

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testStageOnly();
    testBitOrder();
    testFlow();
    testZero();
    testShortWrite();
    testBoundaries();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule